// File: doc/BRIEF.md
# Cascadable Presettable Up/Down Counter

This block is a synchronous binary counter built from a configurable number of identical 4-bit slices. On each rising clock edge it either loads a parallel preset word, steps up by one, steps down by one, or keeps its value. Loading is active low and wins over everything except the reset. Counting needs both active-low enables asserted together: a slice-wide enable, and a chain enable that also gates the terminal-count flag.

Each slice reports an active-low terminal-count flag. The flag is decoded combinationally from the slice's value, the direction and its chain enable. Inside the wrapper, each slice's flag drives the chain enable of the next more significant slice. All slices share the clock, the direction, the load strobe and the slice-wide enable, so the wide value moves as one synchronous word. The flag of the most significant slice is exported, so a further wrapper can be chained without extra gating. A synchronous active-high reset clears the value to zero and exists so that a bench can start from a known state.

Top module: `updown_cascade_counter`

## Requirements
- R1: When `load_n` is 0 at a rising edge, `count` takes `preset_data` at that edge, whatever the values of `cnt_en_n` and `chain_en_n`.
- R2: With `load_n`=1, `cnt_en_n`=0, `chain_en_n`=0 and `dir_up`=1, `count` increases by one at the edge, modulo 2^W.
- R3: With `load_n`=1, `cnt_en_n`=0, `chain_en_n`=0 and `dir_up`=0, `count` decreases by one at the edge, modulo 2^W.
- R4: With `load_n`=1 and either `cnt_en_n` or `chain_en_n` at 1, `count` keeps its value.
- R5: `term_n` is 0 exactly when `chain_en_n` is 0 and `count` is all ones with `dir_up`=1, or all zeros with `dir_up`=0. It follows its inputs in the same cycle, with no clock edge.
- R6: `term_n` does not depend on `cnt_en_n`.
- R7: The wide value wraps from all ones to zero going up and from zero to all ones going down. A carry or borrow crosses every 4-bit slice boundary in the cycle it occurs.
- R8: When `srst` is 1 at a rising edge, `count` becomes 0. This overrides the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| srst | input | 1 | Synchronous reset, active high, clears the count |
| load_n | input | 1 | Parallel load strobe, active low |
| dir_up | input | 1 | 1 counts up, 0 counts down |
| cnt_en_n | input | 1 | Count enable shared by all slices, active low |
| chain_en_n | input | 1 | Chain enable into the least significant slice, active low; also gates `term_n` |
| preset_data | input | 4*NUM_STAGES | Value loaded when `load_n` is 0 |
| count | output | 4*NUM_STAGES | Current counter value |
| term_n | output | 1 | Terminal count of the most significant slice, active low |

## Verification
Vectors start from a load of 13. From there they count up across the 15-to-16 slice boundary, pause once with each enable, and then count down. This separates a slice that counts alone from a chain that carries correctly, and it shows whether each enable holds the value on its own. A load applied with both enables asserted tests load priority. Vectors parked at all ones and at zero, with each enable toggled in turn, show whether the flag is gated by the chain enable and not by the slice-wide enable. Full passes up and down through every value, compared with a wide integer model, expose carry or borrow errors at any nibble boundary. Changing the direction between edges checks that the flag decode is combinational.

// File: rtl/ucc_pkg.sv
package ucc_pkg;
   localparam int unsigned SLICE_W = 4;

   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_LOAD = 2'd1,
      ACT_INC  = 2'd2,
      ACT_DEC  = 2'd3
   } slice_act_e;

   function automatic slice_act_e pick_action(input logic load_n,
                                              input logic cnt_en_n,
                                              input logic chain_en_n,
                                              input logic dir_up);
      if (!load_n)                      return ACT_LOAD;
      else if (!cnt_en_n && !chain_en_n) return dir_up ? ACT_INC : ACT_DEC;
      else                              return ACT_HOLD;
   endfunction
endpackage

// File: rtl/ucc_tc_decode.sv
module ucc_tc_decode #(
   parameter int unsigned W = ucc_pkg::SLICE_W
) (
   input  logic [W-1:0] value,
   input  logic         dir_up,
   input  logic         chain_en_n,
   output logic         term_n
);
   logic at_top;
   logic at_bottom;

   always_comb begin
      at_top    = &value;
      at_bottom = ~|value;
      term_n    = ~(~chain_en_n & (dir_up ? at_top : at_bottom));
   end
endmodule

// File: rtl/ucc_slice.sv
module ucc_slice
   import ucc_pkg::*;
#(
   parameter int unsigned W = SLICE_W
) (
   input  logic         clk,
   input  logic         srst,
   input  logic         load_n,
   input  logic         dir_up,
   input  logic         cnt_en_n,
   input  logic         chain_en_n,
   input  logic [W-1:0] preset,
   output logic [W-1:0] value,
   output logic         term_n
);
   if (W < 1) begin : g_bad_w
      $error("ucc_slice: W must be at least 1");
   end

   slice_act_e   act;
   logic [W-1:0] nxt;

   always_comb begin
      act = pick_action(load_n, cnt_en_n, chain_en_n, dir_up);
      unique case (act)
         ACT_LOAD: nxt = preset;
         ACT_INC:  nxt = value + W'(1);
         ACT_DEC:  nxt = value - W'(1);
         default:  nxt = value;
      endcase
   end

   always_ff @(posedge clk) begin
      if (srst) value <= '0;
      else      value <= nxt;
   end

   ucc_tc_decode #(.W(W)) tc_i (
      .value      (value),
      .dir_up     (dir_up),
      .chain_en_n (chain_en_n),
      .term_n     (term_n)
   );

   // R1: load wins over both enables
   a_r1_load_wins: assert property (@(posedge clk) disable iff (srst)
      !load_n |=> value == $past(preset));
   // R4: either enable high freezes the slice
   a_r4_hold: assert property (@(posedge clk) disable iff (srst)
      (load_n && (cnt_en_n || chain_en_n)) |=> $stable(value));
   // R2: step up
   a_r2_step_up: assert property (@(posedge clk) disable iff (srst)
      (load_n && !cnt_en_n && !chain_en_n && dir_up) |=> value == W'($past(value) + W'(1)));
   // R3: step down
   a_r3_step_down: assert property (@(posedge clk) disable iff (srst)
      (load_n && !cnt_en_n && !chain_en_n && !dir_up) |=> value == W'($past(value) - W'(1)));
   // R5: flag stays high while the chain enable is deasserted
   a_r5_flag_gated: assert property (@(posedge clk) disable iff (srst)
      chain_en_n |-> term_n);
   // R8: reset clears the slice
   a_r8_reset_clears: assert property (@(posedge clk)
      srst |=> value == '0);
endmodule

// File: rtl/updown_cascade_counter.sv
module updown_cascade_counter
   import ucc_pkg::*;
#(
   parameter int unsigned NUM_STAGES = 2,
   localparam int unsigned W = NUM_STAGES * SLICE_W
) (
   input  logic         clk,
   input  logic         srst,
   input  logic         load_n,
   input  logic         dir_up,
   input  logic         cnt_en_n,
   input  logic         chain_en_n,
   input  logic [W-1:0] preset_data,
   output logic [W-1:0] count,
   output logic         term_n
);
   if (NUM_STAGES < 1 || NUM_STAGES > 64) begin : g_bad_stages
      $error("updown_cascade_counter: NUM_STAGES must be 1..64");
   end

   logic [NUM_STAGES-1:0] stage_tc_n;
   logic [NUM_STAGES-1:0] stage_chain_n;

   for (genvar k = 0; k < NUM_STAGES; k++) begin : g_slice
      if (k == 0) begin : g_lsb
         assign stage_chain_n[k] = chain_en_n;
      end else begin : g_upper
         assign stage_chain_n[k] = stage_tc_n[k-1];
      end

      ucc_slice #(.W(SLICE_W)) slice_i (
         .clk        (clk),
         .srst       (srst),
         .load_n     (load_n),
         .dir_up     (dir_up),
         .cnt_en_n   (cnt_en_n),
         .chain_en_n (stage_chain_n[k]),
         .preset     (preset_data[k*SLICE_W +: SLICE_W]),
         .value      (count[k*SLICE_W +: SLICE_W]),
         .term_n     (stage_tc_n[k])
      );
   end

   assign term_n = stage_tc_n[NUM_STAGES-1];

   // R7: whole word carries through every slice boundary
   a_r7_wide_up: assert property (@(posedge clk) disable iff (srst)
      (load_n && !cnt_en_n && !chain_en_n && dir_up) |=> count == W'($past(count) + W'(1)));
   a_r7_wide_down: assert property (@(posedge clk) disable iff (srst)
      (load_n && !cnt_en_n && !chain_en_n && !dir_up) |=> count == W'($past(count) - W'(1)));
   // R5: wide flag low only at the end of the range in the current direction
   a_r5_wide_flag: assert property (@(posedge clk) disable iff (srst)
      !term_n |-> (!chain_en_n && (dir_up ? (count == {W{1'b1}}) : (count == '0))));
endmodule

// File: tb/updown_cascade_counter_tb_top.sv
module updown_cascade_counter_tb_top;
   localparam int NS = 2;
   localparam int W  = NS * 4;
   localparam int NV = 20;

   logic         clk = 1'b0;
   logic         srst = 1'b1;
   logic         load_n = 1'b1;
   logic         dir_up = 1'b1;
   logic         cnt_en_n = 1'b1;
   logic         chain_en_n = 1'b1;
   logic [W-1:0] preset_data = '0;
   logic [W-1:0] count;
   logic         term_n;

   int n_checks = 0;
   int n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   updown_cascade_counter #(.NUM_STAGES(NS)) dut_i (
      .clk(clk), .srst(srst), .load_n(load_n), .dir_up(dir_up),
      .cnt_en_n(cnt_en_n), .chain_en_n(chain_en_n),
      .preset_data(preset_data), .count(count), .term_n(term_n)
   );

   // fields: load_n, dir_up, cnt_en_n, chain_en_n, data, expected count, expected term_n
   localparam logic [20:0] VEC [0:NV-1] = '{
      {1'b0,1'b1,1'b1,1'b1,8'h0D,8'h0D,1'b1}, // R1 load 13
      {1'b1,1'b1,1'b0,1'b0,8'h00,8'h0E,1'b1}, // R2
      {1'b1,1'b1,1'b0,1'b0,8'h00,8'h0F,1'b1}, // R2
      {1'b1,1'b1,1'b0,1'b0,8'h00,8'h10,1'b1}, // R7 nibble carry
      {1'b1,1'b1,1'b1,1'b0,8'h00,8'h10,1'b1}, // R4 slice enable off
      {1'b1,1'b1,1'b0,1'b1,8'h00,8'h10,1'b1}, // R4 chain enable off
      {1'b1,1'b0,1'b0,1'b0,8'h00,8'h0F,1'b1}, // R3 nibble borrow
      {1'b1,1'b0,1'b0,1'b0,8'h00,8'h0E,1'b1}, // R3
      {1'b0,1'b1,1'b0,1'b0,8'hFE,8'hFE,1'b1}, // R1 load beats enables
      {1'b1,1'b1,1'b0,1'b0,8'h00,8'hFF,1'b0}, // R5 top reached
      {1'b1,1'b1,1'b1,1'b0,8'h00,8'hFF,1'b0}, // R6 flag ignores cnt_en_n
      {1'b1,1'b1,1'b0,1'b0,8'h00,8'h00,1'b1}, // R7 wrap up
      {1'b1,1'b0,1'b0,1'b0,8'h00,8'hFF,1'b1}, // R7 wrap down
      {1'b1,1'b0,1'b0,1'b0,8'h00,8'hFE,1'b1}, // R3
      {1'b0,1'b0,1'b1,1'b1,8'h01,8'h01,1'b1}, // R1
      {1'b1,1'b0,1'b0,1'b0,8'h00,8'h00,1'b0}, // R5 bottom reached
      {1'b1,1'b0,1'b1,1'b0,8'h00,8'h00,1'b0}, // R6
      {1'b1,1'b0,1'b0,1'b1,8'h00,8'h00,1'b1}, // R5 gated by chain enable
      {1'b1,1'b0,1'b0,1'b0,8'h00,8'hFF,1'b1}, // R3 / R7
      {1'b0,1'b1,1'b0,1'b0,8'hF0,8'hF0,1'b1}  // R1
   };

   task automatic check(input string req, input logic [W-1:0] c_exp, input logic t_exp);
      n_checks++;
      if (count !== c_exp || term_n !== t_exp) begin
         n_bad++;
         $display("FAIL %s: count=%h term_n=%b expected count=%h term_n=%b",
                  req, count, term_n, c_exp, t_exp);
      end
   endtask

   task automatic step(input logic ld, input logic up, input logic ce, input logic ch,
                       input logic [W-1:0] d);
      @(negedge clk);
      load_n = ld; dir_up = up; cnt_en_n = ce; chain_en_n = ch; preset_data = d;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_checks++; n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("test done: total=%0d bad=%0d", n_checks, n_bad);
         $finish;
      end
   end

   initial begin
      int unsigned ref_v;
      repeat (2) @(posedge clk);
      #1;
      check("R8 reset state", '0, 1'b1);
      @(negedge clk);
      srst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16:9]);
         check($sformatf("R1-7 vector %0d", i), VEC[i][8:1], VEC[i][0]);
      end

      // R5: flag follows dir_up with no clock edge (count is F0 here, go to 00)
      step(1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
      check("R5 at zero, down", 8'h00, 1'b0);
      @(negedge clk);
      dir_up = 1'b1;
      #0.5;
      check("R5 combinational dir change", 8'h00, 1'b1);
      chain_en_n = 1'b1; dir_up = 1'b0;
      #0.5;
      check("R5 combinational chain gate", 8'h00, 1'b1);

      // R7 / R2: full pass up against wide integer model
      ref_v = 0;
      for (int i = 0; i < 300; i++) begin
         step(1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
         ref_v = (ref_v + 1) % (1 << W);
         check("R2 R7 up sweep", W'(ref_v), (ref_v == (1 << W) - 1) ? 1'b0 : 1'b1);
      end
      // R7 / R3: full pass down
      for (int i = 0; i < 300; i++) begin
         step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
         ref_v = (ref_v + (1 << W) - 1) % (1 << W);
         check("R3 R7 down sweep", W'(ref_v), (ref_v == 0) ? 1'b0 : 1'b1);
      end

      // R8: reset overrides a simultaneous load
      @(negedge clk);
      srst = 1'b1; load_n = 1'b0; preset_data = 8'hA5;
      @(posedge clk);
      #1;
      check("R8 reset beats load", 8'h00, 1'b0);
      @(negedge clk);
      srst = 1'b0;
      step(1'b0, 1'b1, 1'b1, 1'b1, 8'hA5);
      check("R1 load after reset", 8'hA5, 1'b1);

      done = 1;
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end
endmodule